// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits at the head of an Ethernet receive path and decides, from the six destination address bytes that open each frame, whether the frame is kept or dropped. The bytes arrive one per valid cycle. A start strobe marks the first byte of a frame. The filter keeps a running CRC over the bytes and compares them with a programmed station address, and it also watches for the all-ones broadcast pattern.

Once the sixth byte has been taken, the filter issues a single-cycle done strobe together with an accept flag. The verdict is worked out in a fixed priority order. The receive enable comes first and vetoes everything. Then come promiscuous mode, an exact station match, broadcast, and finally a 64-bit multicast hash table indexed by the top six bits of the CRC.

Configuration is written through a narrow write port into eight 16-bit words. The rest of the frame (payload, padding, storage) is handled elsewhere.

Top module: `rx_dst_filter`

## Requirements
- R1: Configuration address 0 is the control word. In it, bit 0 is receive enable, bit 6 is promiscuous and bit 11 is hash enable. Addresses 1, 2 and 3 hold station words 0, 1 and 2. Address 7-k holds hash word k (k = 0..3). A write takes effect for frames whose sixth byte arrives after the write edge.
- R2: While receive enable is 0, every frame is rejected, including in promiscuous mode.
- R3: With receive enable and promiscuous both set, every frame is accepted whatever its address.
- R4: Station word j holds destination byte 2j in bits 15:8 and byte 2j+1 in bits 7:0, where byte 0 is the first on the stream. A frame whose six bytes all equal these is accepted, and a frame that differs in any byte does not match.
- R5: A frame whose six destination bytes are all 0xFF is accepted when receive is enabled.
- R6: When neither the station nor the broadcast check matches and hash enable is set, the index is bits 31:26 of a CRC-32 over the six bytes. The CRC is reflected, with polynomial 0xEDB88320 and start value 0xFFFFFFFF, each byte is taken LSB first, and the result is not inverted. Index bits 5:4 select hash word k and bits 3:0 select the bit within it. The frame is accepted exactly when that bit is 1.
- R7: When no check passes and hash enable is clear, the frame is rejected.
- R8: The done strobe is high for exactly one cycle per frame, in the cycle after the edge that takes the sixth byte. Bytes after the sixth, and valid bytes that arrive with no frame open, produce no strobe.
- R9: A start strobe in the middle of a frame discards the partial address and restarts the CRC and the comparisons from that byte.
- R10: After reset, done and accept are 0 and every configuration word is cleared, so frames are rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word select |
| cfg_wdata | input | 16 | Configuration write data |
| rx_valid | input | 1 | Address byte valid |
| rx_sof | input | 1 | First byte of a frame |
| rx_byte | input | 8 | Address byte |
| filt_done | output | 1 | One-cycle verdict strobe |
| filt_accept | output | 1 | Verdict; meaningful with filt_done |

## Verification
The verdict is due on the outputs one clock after the rising edge that registers the sixth byte, and it stays there for exactly that one cycle. The bench drives bytes and configuration writes at falling edges. It reads done and accept at the first falling edge after the sixth byte is taken, and it checks at the next falling edge that the strobe has dropped. A separate falling-edge monitor counts strobes, and the bench compares that count with one per frame (or zero for stray bytes) only after the frame has fully drained, so the count never races the strobe.

// File: rtl/daf_pkg.sv
package daf_pkg;
    localparam int WORD_W      = 16;
    localparam int BYTE_W      = 8;
    localparam int ADDR_BYTES  = 6;
    localparam int STA_WORDS   = ADDR_BYTES / 2;
    localparam int HASH_WORDS  = 4;
    localparam int HASH_IDX_W  = $clog2(HASH_WORDS * WORD_W);
    localparam int HSEL_W      = $clog2(HASH_WORDS);
    localparam int HBIT_W      = $clog2(WORD_W);
    localparam int CRC_W       = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB8_8320;
    localparam int CFG_ADDR_W  = 3;
    localparam int CNT_W       = $clog2(ADDR_BYTES + 1);

    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_PROM_BIT = 6;
    localparam int CTL_HASH_BIT = 11;

    localparam int CFG_CTRL_ADR = 0;
    localparam int CFG_STA_ADR  = 1;
    localparam int CFG_HASH_TOP = 7;

    typedef struct packed {
        logic en;
        logic prom;
        logic hen;
    } ctl_t;

    typedef struct packed {
        ctl_t                               ctl;
        logic [STA_WORDS-1:0][WORD_W-1:0]   sta;
        logic [HASH_WORDS-1:0][WORD_W-1:0]  hash;
    } cfg_t;
endpackage

// File: rtl/daf_crc_step.sv
module daf_crc_step #(
    parameter int               W    = 32,
    parameter int               BW   = 8,
    parameter logic [W-1:0]     POLY = 32'hEDB8_8320
) (
    input  logic [W-1:0]  crc_i,
    input  logic [BW-1:0] byte_i,
    output logic [W-1:0]  crc_o
);
    logic [BW:0][W-1:0] chain;

    assign chain[0] = crc_i;

    // one reflected shift per data bit, LSB of the byte first
    for (genvar i = 0; i < BW; i++) begin : g_bit
        assign chain[i+1] = (chain[i] >> 1) ^
                            (((chain[i][0] ^ byte_i[i]) != 1'b0) ? POLY : '0);
    end

    assign crc_o = chain[BW];
endmodule

// File: rtl/daf_cfg_regs.sv
module daf_cfg_regs
    import daf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we_i,
    input  logic [CFG_ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0]     wdata_i,
    output cfg_t                  cfg_o
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            if (int'(addr_i) == CFG_CTRL_ADR) begin
                cfg_d.ctl.en   = wdata_i[CTL_EN_BIT];
                cfg_d.ctl.prom = wdata_i[CTL_PROM_BIT];
                cfg_d.ctl.hen  = wdata_i[CTL_HASH_BIT];
            end
            for (int j = 0; j < STA_WORDS; j++) begin
                if (int'(addr_i) == CFG_STA_ADR + j) cfg_d.sta[j] = wdata_i;
            end
            // hash words sit in descending address order
            for (int k = 0; k < HASH_WORDS; k++) begin
                if (int'(addr_i) == CFG_HASH_TOP - k) cfg_d.hash[k] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(cfg_q)) else $error("cfg changed without write"); // R1
endmodule

// File: rtl/daf_addr_track.sv
module daf_addr_track
    import daf_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             in_valid,
    input  logic                             in_sof,
    input  logic [BYTE_W-1:0]                in_byte,
    input  logic [STA_WORDS-1:0][WORD_W-1:0] sta_i,
    output logic                             last_o,
    output logic [HASH_IDX_W-1:0]            hidx_o,
    output logic                             sta_hit_o,
    output logic                             bcast_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CRC_W-1:0] crc;
        logic             hit;
        logic             ones;
    } trk_t;

    trk_t trk_d, trk_q;

    logic              take;
    logic [CNT_W-1:0]  pos;
    logic [CRC_W-1:0]  crc_base, crc_nx;
    logic [1:0]        widx;
    logic [BYTE_W-1:0] want;
    logic              hit_nx, ones_nx;

    daf_crc_step #(.W(CRC_W), .BW(BYTE_W), .POLY(CRC_POLY)) u_crc (
        .crc_i  (crc_base),
        .byte_i (in_byte),
        .crc_o  (crc_nx)
    );

    always_comb begin
        take     = in_valid && (in_sof ||
                   (trk_q.cnt != '0 && int'(trk_q.cnt) < ADDR_BYTES));
        pos      = in_sof ? '0 : trk_q.cnt;
        crc_base = in_sof ? '1 : trk_q.crc;
        widx     = (int'(pos) < ADDR_BYTES) ? pos[2:1] : 2'd0;
        want     = pos[0] ? sta_i[widx][BYTE_W-1:0]
                          : sta_i[widx][WORD_W-1:BYTE_W];
        hit_nx   = (in_sof || trk_q.hit)  && (in_byte == want);
        ones_nx  = (in_sof || trk_q.ones) && (in_byte == '1);

        trk_d = trk_q;
        if (take) begin
            trk_d.cnt  = pos + 1'b1;
            trk_d.crc  = crc_nx;
            trk_d.hit  = hit_nx;
            trk_d.ones = ones_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign last_o    = take && (int'(pos) == ADDR_BYTES - 1);
    assign hidx_o    = crc_nx[CRC_W-1 -: HASH_IDX_W];
    assign sta_hit_o = hit_nx;
    assign bcast_o   = ones_nx;

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(trk_q.cnt) <= ADDR_BYTES) else $error("byte count overran"); // R8
    AST_SOF_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof) |=> (trk_q.cnt == CNT_W'(1))) else $error("start did not restart"); // R9
endmodule

// File: rtl/daf_decide.sv
module daf_decide
    import daf_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              last_i,
    input  logic [HASH_IDX_W-1:0]             hidx_i,
    input  logic                              sta_hit_i,
    input  logic                              bcast_i,
    input  ctl_t                              ctl_i,
    input  logic [HASH_WORDS-1:0][WORD_W-1:0] hash_i,
    output logic                              done_o,
    output logic                              accept_o
);
    typedef struct packed {
        logic done;
        logic accept;
    } dec_t;

    dec_t dec_d, dec_q;

    logic [HSEL_W-1:0] hsel;
    logic [HBIT_W-1:0] hbit;
    logic              tbl_bit;
    logic              verdict;

    always_comb begin
        hsel    = hidx_i[HASH_IDX_W-1 -: HSEL_W];
        hbit    = hidx_i[HBIT_W-1:0];
        tbl_bit = hash_i[hsel][hbit];

        // fixed priority: enable, promiscuous, station, broadcast, hash
        if (!ctl_i.en)       verdict = 1'b0;
        else if (ctl_i.prom) verdict = 1'b1;
        else if (sta_hit_i)  verdict = 1'b1;
        else if (bcast_i)    verdict = 1'b1;
        else if (ctl_i.hen)  verdict = tbl_bit;
        else                 verdict = 1'b0;

        dec_d.done   = last_i;
        dec_d.accept = last_i && verdict;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign done_o   = dec_q.done;
    assign accept_o = dec_q.accept;

    AST_ACCEPT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_q.accept |-> dec_q.done) else $error("accept without done"); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_q.done |=> !dec_q.done) else $error("done longer than a cycle"); // R8
    AST_DISABLED_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (last_i && !ctl_i.en) |=> (dec_q.done && !dec_q.accept)) else $error("accept while disabled"); // R2
    AST_PROMISC_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (last_i && ctl_i.en && ctl_i.prom) |=> dec_q.accept) else $error("promiscuous reject"); // R3
    AST_NO_HASH_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (last_i && !ctl_i.prom && !sta_hit_i && !bcast_i && !ctl_i.hen) |=> !dec_q.accept) else $error("accept with no match"); // R7
endmodule

// File: rtl/rx_dst_filter.sv
module rx_dst_filter
    import daf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [WORD_W-1:0]     cfg_wdata,
    input  logic                  rx_valid,
    input  logic                  rx_sof,
    input  logic [BYTE_W-1:0]     rx_byte,
    output logic                  filt_done,
    output logic                  filt_accept
);
    cfg_t                  cfg;
    logic                  last;
    logic [HASH_IDX_W-1:0] hidx;
    logic                  sta_hit;
    logic                  bcast;

    daf_cfg_regs u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .addr_i  (cfg_addr),
        .wdata_i (cfg_wdata),
        .cfg_o   (cfg)
    );

    daf_addr_track u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rx_valid),
        .in_sof    (rx_sof),
        .in_byte   (rx_byte),
        .sta_i     (cfg.sta),
        .last_o    (last),
        .hidx_o    (hidx),
        .sta_hit_o (sta_hit),
        .bcast_o   (bcast)
    );

    daf_decide u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .last_i    (last),
        .hidx_i    (hidx),
        .sta_hit_i (sta_hit),
        .bcast_i   (bcast),
        .ctl_i     (cfg.ctl),
        .hash_i    (cfg.hash),
        .done_o    (filt_done),
        .accept_o  (filt_accept)
    );
endmodule

// File: tb/tb_rx_dst_filter.sv
module tb_rx_dst_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        rx_valid = 1'b0;
    logic        rx_sof = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        filt_done;
    logic        filt_accept;

    int total = 0;
    int bad = 0;
    int done_cnt = 0;
    bit finished = 0;

    logic [15:0] ctl_m = '0;
    logic [15:0] sta_m [3];
    logic [15:0] hash_m [4];

    rx_dst_filter dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_byte(rx_byte), .filt_done(filt_done), .filt_accept(filt_accept)
    );

    always #4 clk = ~clk;

    always @(negedge clk) if (filt_done) done_cnt++;

    task automatic chk(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic chk_int(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] crc6(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) begin
            logic [7:0] b = a[47-8*i -: 8];
            for (int k = 0; k < 8; k++) begin
                logic fb = c[0] ^ b[k];
                c = c >> 1;
                if (fb) c = c ^ 32'hEDB8_8320;
            end
        end
        return c;
    endfunction

    function automatic logic model(input logic [47:0] a);
        logic [5:0] idx;
        if (!ctl_m[0]) return 1'b0;
        if (ctl_m[6]) return 1'b1;
        if (a == {sta_m[0], sta_m[1], sta_m[2]}) return 1'b1;
        if (a == 48'hFFFF_FFFF_FFFF) return 1'b1;
        if (ctl_m[11]) begin
            idx = crc6(a)[31:26];
            return hash_m[idx[5:4]][idx[3:0]];
        end
        return 1'b0;
    endfunction

    task automatic cfg_write(input int a, input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a == 0) ctl_m = v;
        else if (a <= 3) sta_m[a-1] = v;
        else hash_m[7-a] = v;
    endtask

    task automatic set_hash(input logic [63:0] t);
        for (int k = 0; k < 4; k++) cfg_write(7 - k, t[16*k +: 16]);
    endtask

    task automatic stray(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = 1'b0; rx_byte = 8'(8'h11 * i);
        end
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic frame(input logic [47:0] a, input int gap, input int trail,
                         input string tag);
        logic exp = model(a);
        done_cnt = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = (i == 0); rx_byte = a[47-8*i -: 8];
            for (int g = 0; g < gap && i < 5; g++) begin
                @(negedge clk);
                rx_valid = 1'b0; rx_sof = 1'b0;
            end
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0;
        chk(filt_done, 1'b1, {tag, " done"});
        chk(filt_accept, exp, {tag, " accept"});
        if (trail > 0) stray(trail);
        @(negedge clk);
        chk(filt_done, 1'b0, {"R8 strobe drop ", tag});
        @(negedge clk);
        chk_int(done_cnt, 1, {"R8 one strobe ", tag});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [47:0] st;
        logic [47:0] a;
        for (int k = 0; k < 3; k++) sta_m[k] = '0;
        for (int k = 0; k < 4; k++) hash_m[k] = '0;
        repeat (3) @(negedge clk);
        chk(filt_done, 1'b0, "R10 reset done");
        chk(filt_accept, 1'b0, "R10 reset accept");
        rst_n = 1'b1;
        @(negedge clk);
        chk(filt_done, 1'b0, "R10 after release done");
        frame(48'hFFFF_FFFF_FFFF, 0, 0, "R10 cleared config rejects");

        // R2: promiscuous without enable still rejects
        cfg_write(0, 16'h0040);
        frame(48'h1234_5678_9ABC, 0, 0, "R2 disabled promisc");
        frame(48'hFFFF_FFFF_FFFF, 1, 0, "R2 disabled bcast");

        // R3 promiscuous
        cfg_write(0, 16'h0041);
        frame(48'h1234_5678_9ABC, 0, 0, "R3 promisc any");
        frame(48'h0000_0000_0000, 2, 0, "R3 promisc zero");

        // R4 station match and byte placement (R1 word addresses)
        st = 48'h0A1B_2C3D_4E5F;
        cfg_write(1, st[47:32]);
        cfg_write(2, st[31:16]);
        cfg_write(3, st[15:0]);
        cfg_write(0, 16'h0001);
        frame(st, 0, 0, "R4 station exact");
        frame(st, 3, 0, "R4 station gapped");
        for (int i = 0; i < 6; i++) begin
            a = st;
            a[47-8*i -: 8] = a[47-8*i -: 8] ^ 8'h80;
            frame(a, 0, 0, $sformatf("R4 byte %0d differs", i));
        end
        frame({st[15:0], st[31:16], st[47:32]}, 0, 0, "R4 word order");
        frame({st[39:32], st[47:40], st[31:0]}, 0, 0, "R4 byte order");

        // R5 broadcast, R7 near-broadcast with hash off
        frame(48'hFFFF_FFFF_FFFF, 0, 0, "R5 broadcast");
        frame(48'hFFFF_FFFF_FFFE, 0, 0, "R7 near broadcast");
        frame(48'h7FFF_FFFF_FFFF, 0, 0, "R7 near broadcast hi");

        // R8 trailing bytes and stray bytes
        frame(st, 0, 4, "R8 trailing bytes");
        done_cnt = 0;
        stray(8);
        repeat (2) @(negedge clk);
        chk_int(done_cnt, 0, "R8 stray bytes no strobe");

        // R9 restart mid-frame
        done_cnt = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = (i == 0); rx_byte = 8'h55;
        end
        frame(st, 0, 0, "R9 restart");

        // R6 hash sweep: single bit set, then all but that bit
        cfg_write(0, 16'h0801);
        for (int k = 0; k < 64; k++) begin
            logic [5:0] idx;
            a = {8'h01, 8'h00, 8'h5E, 8'(k), 8'(k) ^ 8'hA5, 8'h3C};
            idx = crc6(a)[31:26];
            set_hash(64'd1 << idx);
            frame(a, 0, 0, $sformatf("R6 hit k=%0d idx=%0d", k, idx));
            set_hash(~(64'd1 << idx));
            frame(a, 0, 0, $sformatf("R6 miss k=%0d idx=%0d", k, idx));
        end

        // R7 hash disabled with full table
        set_hash('1);
        cfg_write(0, 16'h0001);
        frame(48'h0100_5E00_0001, 0, 0, "R7 hash off full table");

        // R1 control rewrite takes effect
        cfg_write(0, 16'h0000);
        frame(st, 0, 0, "R1 enable cleared");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule